// File: doc/BRIEF.md
# UART FIFO Interrupt and Transmit-Status Generator

This block sits next to the 16-entry transmit and receive FIFOs of a UART. It decides when the interrupt request is raised and produces the two transmitter-status flags of the line status register. The FIFOs themselves are outside the block. Their fill levels come in as counts, and the serializer reports through per-character completion strobes and a shift-register-idle flag.

Two interrupt policies are supported. In the character policy, each completed transmit or receive character raises a one-cycle request. This policy applies when the FIFOs are disabled, and also when they are enabled with the DMA select bit at 0. In the block policy (FIFOs enabled and DMA select at 1), the request follows thresholds. It is high while the transmit FIFO has room, or while the receive FIFO holds more characters than the programmed trigger level.

A power-down interlock needs two independent control bits, one from the modem control register and one from the interrupt enable register, to be set together. While it is engaged, the interrupt is forced low and a registered power-down flag is exported for clock gating. All outputs are registered.

Top module: `uart_dma_irq_gen`

## Requirements
- R1: After a synchronous reset, `irq`, `thr_room`, `tx_all_empty` and `pd_active` are all 0.
- R2: With `fifo_en`=1, `dma_sel`=0 and power-down not requested, `irq` is 1 in the cycle after a cycle in which `tx_char_done` or `rx_char_done` is 1, and 0 in the cycle after a cycle in which neither is 1.
- R3: With `fifo_en`=0, `dma_sel` has no effect and `irq` follows the per-character rule of R2.
- R4: With `fifo_en`=1 and `dma_sel`=1 and power-down not requested, `irq` is 1 in the cycle after `tx_fill` is below 16.
- R5: In the block policy, `irq` is 1 in the cycle after `rx_fill` exceeds the trigger level. The level is selected by `rx_trig_sel`: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 characters.
- R6: In the block policy, the character strobes have no effect. `irq` is 0 in the cycle after `tx_fill`=16 and `rx_fill` is at or below the trigger level.
- R7: `thr_room` is 1 in the cycle after `tx_fill` is below 16, and 0 otherwise.
- R8: `tx_all_empty` is 1 in the cycle after `tx_fill`=0 and `tsr_idle`=1 hold together, and 0 otherwise.
- R9: `pd_active` is 1 in the cycle after `mcr_pd_bit` and `ier_pd_bit` are both 1. It returns to 0 in the cycle after either of them is 0.
- R10: In the cycle after both power-down bits are 1, `irq` is 0 whatever the other inputs are.
- R11: `irq` falls in the cycle after the condition that raised it goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_sel | input | 1 | Block (DMA) interrupt policy select |
| rx_trig_sel | input | 2 | Receive trigger level code |
| tx_fill | input | CNT_W (5) | Transmit FIFO fill count, 0..16 |
| rx_fill | input | CNT_W (5) | Receive FIFO fill count, 0..16 |
| tsr_idle | input | 1 | Transmit shift register idle |
| tx_char_done | input | 1 | One-cycle strobe per transmitted character |
| rx_char_done | input | 1 | One-cycle strobe per received character |
| mcr_pd_bit | input | 1 | Power-down enable from the modem control register |
| ier_pd_bit | input | 1 | Power-down enable from the interrupt enable register |
| irq | output | 1 | Registered interrupt request |
| thr_room | output | 1 | Line status: transmit FIFO has a free location |
| tx_all_empty | output | 1 | Line status: transmit FIFO and shift register empty |
| pd_active | output | 1 | Registered power-down flag |

## Verification
Every output is one register stage away from the inputs that decide it. Each result is therefore due exactly one clock edge after the stimulus. The bench changes inputs on the falling edge and lets the model compute the due values at the rising edge from those same inputs. It compares all four outputs just before the next falling edge, so each comparison falls in the cycle where the result is due. The test sequence covers both interrupt policies and every trigger code on both sides of its threshold. It also walks the two power-down bits through each combination, including removing a cause so that the one-cycle clear can be seen.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_A = 2'd0,
    TRIG_B = 2'd1,
    TRIG_C = 2'd2,
    TRIG_D = 2'd3
  } trig_code_e;

  typedef enum logic {
    POL_CHAR  = 1'b0,
    POL_BLOCK = 1'b1
  } irq_policy_e;

endpackage

// File: rtl/uart_irq_trig_decode.sv
module uart_irq_trig_decode #(
  parameter int DEPTH = 16,
  parameter int LVL_A = 1,
  parameter int LVL_B = 4,
  parameter int LVL_C = 8,
  parameter int LVL_D = 14,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       code,
  output logic [CNT_W-1:0] level
);
  import uart_irq_pkg::*;

  localparam int NUM_LVL = 4;
  localparam int LVLS [NUM_LVL] = '{LVL_A, LVL_B, LVL_C, LVL_D};

  logic [CNT_W-1:0] lvl_tab [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_tab
    assign lvl_tab[g] = CNT_W'(LVLS[g]);
  end

  always_comb begin
    unique case (trig_code_e'(code))
      TRIG_A:  level = lvl_tab[0];
      TRIG_B:  level = lvl_tab[1];
      TRIG_C:  level = lvl_tab[2];
      default: level = lvl_tab[3];
    endcase
  end

  // R5: every decoded level must leave room below the FIFO depth
  always_comb begin
    a_r5_level_range: assert (int'(level) >= 1 && int'(level) < DEPTH)
      else $error("trigger level out of range");
  end
endmodule

// File: rtl/uart_irq_pd_lock.sv
module uart_irq_pd_lock (
  input  logic clk,
  input  logic rst,
  input  logic mcr_bit,
  input  logic ier_bit,
  output logic pd_req,
  output logic pd_q
);
  assign pd_req = mcr_bit & ier_bit;

  always_ff @(posedge clk) begin
    if (rst) pd_q <= 1'b0;
    else     pd_q <= pd_req;
  end

  // R9: both bits engage power-down on the next cycle
  a_r9_pd_enter: assert property (@(posedge clk) disable iff (rst)
    (mcr_bit && ier_bit) |=> pd_q);
  // R9: clearing either bit releases power-down on the next cycle
  a_r9_pd_leave: assert property (@(posedge clk) disable iff (rst)
    (!mcr_bit || !ier_bit) |=> !pd_q);
endmodule

// File: rtl/uart_irq_tx_status.sv
module uart_irq_tx_status #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_fill,
  input  logic             tsr_idle,
  output logic             room_q,
  output logic             empty_q
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic has_room, all_empty;

  assign has_room  = tx_fill < FULL_CNT;
  assign all_empty = (tx_fill == '0) && tsr_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      room_q  <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      room_q  <= has_room;
      empty_q <= all_empty;
    end
  end

  // R8: a busy shift register keeps the empty flag low
  a_r8_busy_not_empty: assert property (@(posedge clk) disable iff (rst)
    !tsr_idle |=> !empty_q);
  // R7: a full transmit FIFO reports no room
  a_r7_full_no_room: assert property (@(posedge clk) disable iff (rst)
    (tx_fill == FULL_CNT) |=> !room_q);
endmodule

// File: rtl/uart_dma_irq_gen.sv
module uart_dma_irq_gen #(
  parameter int DEPTH = 16,
  parameter int LVL_A = 1,
  parameter int LVL_B = 4,
  parameter int LVL_C = 8,
  parameter int LVL_D = 14,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             dma_sel,
  input  logic [1:0]       rx_trig_sel,
  input  logic [CNT_W-1:0] tx_fill,
  input  logic [CNT_W-1:0] rx_fill,
  input  logic             tsr_idle,
  input  logic             tx_char_done,
  input  logic             rx_char_done,
  input  logic             mcr_pd_bit,
  input  logic             ier_pd_bit,
  output logic             irq,
  output logic             thr_room,
  output logic             tx_all_empty,
  output logic             pd_active
);
  import uart_irq_pkg::*;

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] trig_lvl;
  logic             pd_req;
  irq_policy_e      policy;
  logic             block_cause, char_cause, irq_d, irq_q;

  uart_irq_trig_decode #(
    .DEPTH(DEPTH), .LVL_A(LVL_A), .LVL_B(LVL_B),
    .LVL_C(LVL_C), .LVL_D(LVL_D), .CNT_W(CNT_W)
  ) u_trig (
    .code  (rx_trig_sel),
    .level (trig_lvl)
  );

  uart_irq_pd_lock u_pd (
    .clk     (clk),
    .rst     (rst),
    .mcr_bit (mcr_pd_bit),
    .ier_bit (ier_pd_bit),
    .pd_req  (pd_req),
    .pd_q    (pd_active)
  );

  uart_irq_tx_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .tx_fill  (tx_fill),
    .tsr_idle (tsr_idle),
    .room_q   (thr_room),
    .empty_q  (tx_all_empty)
  );

  assign policy      = (fifo_en && dma_sel) ? POL_BLOCK : POL_CHAR;
  assign block_cause = (tx_fill < FULL_CNT) || (rx_fill > trig_lvl);
  assign char_cause  = tx_char_done || rx_char_done;

  always_comb begin
    if (pd_req)                  irq_d = 1'b0;
    else if (policy == POL_BLOCK) irq_d = block_cause;
    else                          irq_d = char_cause;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R10: power-down request silences the interrupt
  a_r10_pd_quiet: assert property (@(posedge clk) disable iff (rst)
    (mcr_pd_bit && ier_pd_bit) |=> !irq);
  // R4: block policy with room in the transmit FIFO raises the request
  a_r4_tx_room_irq: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && dma_sel && !(mcr_pd_bit && ier_pd_bit) && tx_fill < FULL_CNT) |=> irq);
  // R2: character policy without a strobe leaves the request low
  a_r2_no_strobe_low: assert property (@(posedge clk) disable iff (rst)
    (!(fifo_en && dma_sel) && !tx_char_done && !rx_char_done) |=> !irq);
  // R6: block policy with a full transmit FIFO ignores strobes
  a_r6_strobe_ignored: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && dma_sel && tx_fill == FULL_CNT && rx_fill == '0) |=> !irq);
endmodule

// File: tb/uart_dma_irq_gen_tb.sv
module uart_dma_irq_gen_tb;
  localparam int DEPTH = 16;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 0, dma_sel = 0, tsr_idle = 0, txd = 0, rxd = 0, mcr = 0, ier = 0;
  logic [1:0] trig = 0;
  logic [CW-1:0] txf = 0, rxf = 0;
  logic irq, thr_room, tx_all_empty, pd_active;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // expected values and the tag of the rule that produced them
  bit e_irq = 0, e_room = 0, e_empty = 0, e_pd = 0, prev_e_irq = 0;
  string t_irq = "R1", t_room = "R1", t_empty = "R1", t_pd = "R1";

  always #10 clk = ~clk;

  uart_dma_irq_gen u_dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_sel(dma_sel),
    .rx_trig_sel(trig), .tx_fill(txf), .rx_fill(rxf), .tsr_idle(tsr_idle),
    .tx_char_done(txd), .rx_char_done(rxd), .mcr_pd_bit(mcr), .ier_pd_bit(ier),
    .irq(irq), .thr_room(thr_room), .tx_all_empty(tx_all_empty), .pd_active(pd_active)
  );

  function automatic int lvl_of(input int c);
    if (c == 0) return 1;
    if (c == 1) return 4;
    if (c == 2) return 8;
    return 14;
  endfunction

  // behavioural model: evaluated at each rising edge from the inputs held there
  always @(posedge clk) begin
    prev_e_irq = e_irq;
    if (rst) begin
      e_irq = 0; e_room = 0; e_empty = 0; e_pd = 0;
      t_irq = "R1"; t_room = "R1"; t_empty = "R1"; t_pd = "R1";
    end else begin
      e_pd   = mcr && ier;
      t_pd   = "R9";
      e_room = int'(txf) < DEPTH;
      t_room = "R7";
      e_empty = (int'(txf) == 0) && tsr_idle;
      t_empty = "R8";
      if (mcr && ier) begin
        e_irq = 0; t_irq = "R10";
      end else if (fifo_en && dma_sel) begin
        e_irq = (int'(txf) < DEPTH) || (int'(rxf) > lvl_of(int'(trig)));
        if (int'(txf) < DEPTH) t_irq = "R4";
        else if (e_irq) t_irq = "R5";
        else t_irq = "R6";
      end else begin
        e_irq = txd || rxd;
        t_irq = fifo_en ? "R2" : "R3";
      end
      if (prev_e_irq && !e_irq && t_irq != "R10") t_irq = "R11";
    end
  end

  task automatic chk(input string tag, input string nm, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // compare every cycle, just before the falling edge where inputs change
  always @(negedge clk) begin
    #0;
    if (!done) begin
      chk(t_irq, "irq", irq, e_irq);
      chk(t_room, "thr_room", thr_room, e_room);
      chk(t_empty, "tx_all_empty", tx_all_empty, e_empty);
      chk(t_pd, "pd_active", pd_active, e_pd);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    step(3);
    // R1: reset state is checked by the per-cycle comparison above
    rst = 0;
    step(1);
    // R2: character policy with FIFOs enabled
    fifo_en = 1; dma_sel = 0; txf = 16; rxf = 0;
    txd = 1; step(1); txd = 0; step(2);
    rxd = 1; step(1); rxd = 0; step(1);
    txd = 1; rxd = 1; step(2); txd = 0; rxd = 0; step(2);
    // R3: FIFOs disabled, DMA select ignored
    fifo_en = 0; dma_sel = 1; txf = 3; rxf = 16;
    step(2); rxd = 1; step(1); rxd = 0; step(2);
    // R4/R11: block policy, tx room then removed
    fifo_en = 1; dma_sel = 1; txf = 15; rxf = 0; step(2);
    txf = 16; step(2);
    txf = 0; step(1); txf = 16; step(1);
    // R5/R6: every trigger code on both sides of its level
    for (int c = 0; c < 4; c++) begin
      trig = c[1:0];
      rxf = CW'(lvl_of(c)); step(1);
      txd = 1; rxd = 1; step(1); txd = 0; rxd = 0;
      rxf = CW'(lvl_of(c) + 1); step(2);
      rxf = CW'(lvl_of(c)); step(1);
    end
    rxf = 0;
    // R7/R8: status flags
    tsr_idle = 0; txf = 0; step(2);
    tsr_idle = 1; step(2);
    txf = 1; step(1); txf = 16; step(1); txf = 0; step(1);
    tsr_idle = 0; step(1);
    // R9/R10: power-down interlock
    txf = 5;
    mcr = 1; step(2);
    ier = 1; step(3);
    txd = 1; step(1); txd = 0;
    mcr = 0; step(2);
    mcr = 1; step(2);
    ier = 0; step(2);
    mcr = 0; step(2);
    fifo_en = 0; mcr = 1; ier = 1; txd = 1; step(2);
    txd = 0; mcr = 0; ier = 0; step(2);
    // R1: reset again in the middle of activity
    fifo_en = 1; txf = 2; rst = 1; step(2); rst = 0; step(2);
    finish_run();
  end
endmodule